// File: doc/BRIEF.md
# Local-History Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken, using only that branch's own recent outcomes. A first-level table keeps one short history shift register per branch slot. The slot is picked by a field of low-order PC bits. The history read from that slot then addresses a second-level table of 2-bit saturating counters. The top bit of the selected counter is the guess.

Fetch logic presents a PC on the lookup side. It gets back the direction guess and the history value that produced it in the same cycle, with no clock in between. When the branch resolves, the back end returns the PC, the real outcome and the history value captured at lookup time. On the next clock edge the counter chosen by that history moves one step toward the outcome. The history slot picked by the PC is rewritten with the outcome shifted in at its top bit.

Top module: `lhist_predictor`

## Requirements
- R1: After reset every history slot holds 0000 and every counter holds binary 10. Any lookup therefore returns history 0 and a taken guess (`lk_taken`=1).
- R2: The history slot is selected by PC bits [5:2] (16 slots). PCs that differ only in other bits share a slot.
- R3: `lk_hist` equals the selected slot's stored history. `lk_taken` equals bit 1 of the counter addressed by that history. Both follow the lookup PC combinationally.
- R4: On an accepted update, the slot selected by `up_pc` becomes {`up_taken`, `up_hist`[3:1]}. For example, 0000 followed by a taken outcome becomes 1000.
- R5: On an accepted taken update, the counter addressed by `up_hist` increments by one and saturates at 11.
- R6: On an accepted not-taken update, that counter decrements by one and saturates at 00.
- R7: While `up_valid` is 0, no history slot and no counter changes, whatever the other update inputs carry.
- R8: An update becomes visible from the clock edge that accepts it. A lookup in the same cycle as the update sees the old contents.
- R9: The counter is chosen by the history value, not by the PC. Branches in different slots whose histories are equal share one counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | 32 | PC of the branch being looked up |
| lk_taken | output | 1 | Direction guess, 1 = taken |
| lk_hist | output | 4 | History value used for the guess |
| up_valid | input | 1 | Accept a resolved outcome this cycle |
| up_pc | input | 32 | PC of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |
| up_hist | input | 4 | History returned from lookup time |

## Verification
The bench drives one counter against both rails. A design that wraps instead of saturating would flip its guess after a fourth taken or a third not-taken step. A history shifted the wrong way would show 0001 instead of 1000 after a single taken outcome. Checking this exposes a reversed shift and a shift into the wrong end.

Updates are sent with one PC while lookups use a PC in another slot that has the same history. A counter table wrongly addressed by PC would show no change there. The bench also drives an idle update port carrying junk and looks up in the same cycle as an update. These catch writes that ignore the valid bit and writes that are visible too early.

// File: rtl/lhist_predictor.sv
module lhist_predictor #(
  parameter int PC_W    = 32,
  parameter int HIST_W  = 4,
  parameter int HT_SLOTS = 16,
  parameter int IDX_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              lk_taken,
  output logic [HIST_W-1:0] lk_hist,
  input  logic              up_valid,
  input  logic [PC_W-1:0]   up_pc,
  input  logic              up_taken,
  input  logic [HIST_W-1:0] up_hist
);
  localparam int IDX_W    = $clog2(HT_SLOTS);
  localparam int PT_SLOTS = 1 << HIST_W;

  logic [HT_SLOTS-1:0][HIST_W-1:0] ht;
  logic [PT_SLOTS-1:0][1:0]        pt;
  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [1:0]       cnt_cur, cnt_nxt;

  assign lk_idx   = lk_pc[IDX_LSB +: IDX_W];
  assign up_idx   = up_pc[IDX_LSB +: IDX_W];
  assign lk_hist  = ht[lk_idx];
  assign lk_taken = pt[lk_hist][1];
  assign cnt_cur  = pt[up_hist];

  always_comb begin
    cnt_nxt = cnt_cur;
    if (up_taken && cnt_cur != 2'b11) cnt_nxt = cnt_cur + 2'd1;
    else if (!up_taken && cnt_cur != 2'b00) cnt_nxt = cnt_cur - 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ht <= '0;
      for (int i = 0; i < PT_SLOTS; i++) pt[i] <= 2'b10;
    end else if (up_valid) begin
      ht[up_idx]  <= {up_taken, up_hist[HIST_W-1:1]};
      pt[up_hist] <= cnt_nxt;
    end
  end

  // R4
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> ht[$past(up_idx)][HIST_W-1] == $past(up_taken));

  // R5
  sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_taken && pt[up_hist] == 2'b11) |=> pt[$past(up_hist)] == 2'b11);

  // R6
  sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_taken && pt[up_hist] == 2'b00) |=> pt[$past(up_hist)] == 2'b00);

  // R7
  idle_ht_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(ht));

  // R7
  idle_pt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(pt));
endmodule

// File: tb/lhist_predictor_test.sv
module lhist_predictor_test;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [31:0] lk_pc = 0, up_pc = 0;
  logic up_valid = 0, up_taken = 0;
  logic [3:0] up_hist = 0;
  logic lk_taken;
  logic [3:0] lk_hist;

  int nchk = 0, nerr = 0;
  int m_ht[16];
  int m_pt[16];

  always #(PERIOD/2) clk = ~clk;

  lhist_predictor uut (.clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .lk_hist(lk_hist), .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
    .up_hist(up_hist));

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int idx(input logic [31:0] pc);
    return int'(pc[5:2]);
  endfunction

  // one cycle: drive at negedge, compare against model, then apply model at posedge
  task automatic step(input logic [31:0] pc, input logic v, input logic [31:0] upc,
                      input logic t, input logic [3:0] h);
    @(negedge clk);
    lk_pc = pc; up_valid = v; up_pc = upc; up_taken = t; up_hist = h;
    #1;
    chk("R3 hist", int'(lk_hist), m_ht[idx(pc)]);
    chk("R3 taken", int'(lk_taken), m_pt[m_ht[idx(pc)]] / 2);
    @(posedge clk);
    if (v) begin
      m_ht[idx(upc)] = (int'(t) << 3) | (int'(h) >> 1);
      if (t && m_pt[h] < 3) m_pt[h]++;
      else if (!t && m_pt[h] > 0) m_pt[h]--;
    end
  endtask

  task automatic peek(input logic [31:0] pc);
    @(negedge clk);
    lk_pc = pc; up_valid = 0;
    #1;
  endtask

  initial begin
    #(PERIOD * 100000);
    nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_ht[i] = 0; m_pt[i] = 2; end
    repeat (2) @(negedge clk);
    #1;
    chk("R1 hist", int'(lk_hist), 0);
    chk("R1 taken", int'(lk_taken), 1);
    rst_n = 1;

    // R4: single taken shifts into top bit
    step(32'h4, 1, 32'h4, 1, 4'h0);
    peek(32'h4);
    chk("R4 shift", int'(lk_hist), 4'b1000);
    // R2: alias on bits outside [5:2]
    peek(32'hFF04);
    chk("R2 alias", int'(lk_hist), 4'b1000);
    peek(32'h8);
    chk("R2 other slot", int'(lk_hist), 0);
    // R4: second outcome not taken from 1000
    step(32'h4, 1, 32'h4, 0, 4'b1000);
    peek(32'h4);
    chk("R4 shift2", int'(lk_hist), 4'b0100);

    // R5/R6/R9: drive counter 0 via slot 15, watch via slot 2 (history 0)
    step(32'h8, 1, 32'h3C, 1, 4'h0);
    step(32'h8, 1, 32'h3C, 1, 4'h0);
    step(32'h8, 1, 32'h3C, 1, 4'h0);
    peek(32'h8);
    chk("R5 R9 sat high taken", int'(lk_taken), 1);
    step(32'h8, 1, 32'h3C, 0, 4'h0);
    peek(32'h8);
    chk("R5 one below sat", int'(lk_taken), 1);
    step(32'h8, 1, 32'h3C, 0, 4'h0);
    peek(32'h8);
    chk("R6 weak not-taken", int'(lk_taken), 0);
    step(32'h8, 1, 32'h3C, 0, 4'h0);
    step(32'h8, 1, 32'h3C, 0, 4'h0);
    step(32'h8, 1, 32'h3C, 0, 4'h0);
    step(32'h8, 1, 32'h3C, 1, 4'h0);
    peek(32'h8);
    chk("R6 sat low then one up", int'(lk_taken), 0);
    step(32'h8, 1, 32'h3C, 1, 4'h0);
    peek(32'h8);
    chk("R5 back to weak taken", int'(lk_taken), 1);

    // R8: lookup same cycle as update sees old value
    @(negedge clk);
    lk_pc = 32'h10; up_valid = 1; up_pc = 32'h10; up_taken = 1; up_hist = 4'h0;
    #1;
    chk("R8 same cycle old", int'(lk_hist), 0);
    @(posedge clk);
    m_ht[4] = 8; m_pt[0]++;
    #1;
    chk("R8 after edge new", int'(lk_hist), 4'b1000);

    // R7: idle port with junk
    step(32'h10, 0, 32'h10, 0, 4'b1000);
    step(32'h10, 0, 32'h8, 1, 4'h0);
    peek(32'h10);
    chk("R7 hist unchanged", int'(lk_hist), 4'b1000);
    peek(32'h8);
    chk("R7 counter unchanged", int'(lk_taken), 1);

    // loop pattern 1110 on one branch, history fed back from lookup
    for (int k = 0; k < 24; k++) begin
      logic [3:0] hh;
      hh = 4'(m_ht[idx(32'h20)]);
      step(32'h20, 1, 32'h20, (k % 4) != 3, hh);
    end

    // random traffic, checked every cycle against the model
    for (int k = 0; k < 400; k++) begin
      logic [31:0] p, u;
      logic [3:0] hh;
      p = $urandom & 32'hFFFC;
      u = $urandom & 32'hFFFC;
      hh = ($urandom % 4 == 0) ? 4'($urandom) : 4'(m_ht[idx(u)]);
      step(p, 1'($urandom % 3 != 0), u, 1'($urandom), hh);
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule